// File: doc/BRIEF.md
# Seven-to-one serial link transmitter and receiver

This block carries a 28-bit parallel word across five serial lanes. The transmit half takes a word on each rising edge of the parallel clock. It cuts the word into four 7-bit slices and shifts each slice out on its own data lane at seven times the parallel rate. A fifth lane carries a fixed 7-bit clock pattern, sent in step with the data bits of the same word.

The receive half samples the five lanes on the fast clock. It finds the word boundary from the clock-lane pattern alone, so no sync code is placed in the data. It then rebuilds the 28-bit word and produces a recovered parallel clock. A lock flag tells the consumer whether framing can be trusted. The fast clock and the parallel clock are supplied from outside, related and phase aligned. Every parallel rising edge falls on a fast rising edge, and one parallel period spans seven fast cycles.

The two halves have separate ports. They are normally joined by an external loopback or a cable model. Electrical drivers, clock multiplication and lane deskew live outside the block.

Top module: `sl7_link`

## Requirements
- R1: While `rst_n` is low, and after it until the first word has been loaded, all serial outputs, `rx_word`, `rx_par_clk` and `rx_locked` are 0.
- R2: `tx_word` is sampled only on the rising edge of `clk_par`. Changes to `tx_word` between those edges have no effect on the serial outputs.
- R3: For a word sampled on the `clk_par` edge that coincides with fast edge s, data lane n carries word bits 7n+6 down to 7n, highest first. Bit 7n+6-j is driven on `ser_data_o[n]` from fast edge s+1+j until the next fast edge, for j = 0..6.
- R4: In the same seven fast cycles as the data bits of each word, `ser_clk_o` sends the pattern 1,1,0,0,0,1,1.
- R5: `rx_word` updates on the fast edge that follows the sampling of the last bit of a correctly framed clock pattern. It then holds for seven fast cycles. In loopback this is 9 fast cycles after the transmit sampling edge. Bit 7n+k of `rx_word` is the bit received on lane n in position 6-k of the word.
- R6: While not framed, the receiver takes as the word boundary the first seven-bit window of `ser_clk_i` equal to 1100011. That window is the first pair of ones followed by a zero.
- R7: `rx_locked` rises on the capture edge of the third consecutive correctly framed clock pattern.
- R8: If the window at an expected boundary does not match 1100011, `rx_locked` clears on that edge and `rx_word` keeps its previous value. The receiver searches again, and the good-pattern count restarts at one on the next match.
- R9: While framed, `rx_par_clk` is low from each capture edge for three fast cycles and high for the next four. It is low while the receiver is searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock, seven times the parallel rate |
| clk_par | input | 1 | Parallel clock, rising edges aligned with `clk_fast` |
| rst_n | input | 1 | Active-low asynchronous reset for both halves |
| tx_word | input | 28 | Parallel word to transmit |
| ser_data_o | output | 4 | Serial data lanes out |
| ser_clk_o | output | 1 | Forwarded clock lane out |
| ser_data_i | input | 4 | Serial data lanes in |
| ser_clk_i | input | 1 | Forwarded clock lane in |
| rx_word | output | 28 | Reassembled word |
| rx_par_clk | output | 1 | Recovered parallel clock |
| rx_locked | output | 1 | Framing is trusted |

## Verification
At the expected-boundary edge the framer does two things together: it judges the clock window, and it either captures the data or holds the word and drops lock. The bench forces the two onto one edge by inverting the final bit of one word's clock pattern on the loopback path. On that edge the reference model expects the lock flag to fall and the word to stay at the previous value. It then expects three more captures before the lock returns. On the transmit side, `tx_word` is changed in the middle of every parallel period. Each lane is compared bit by bit with the value taken at the last parallel edge.

// File: rtl/sl7_pkg.sv
package sl7_pkg;

    localparam int DEF_LANES      = 4;
    localparam int DEF_LANE_BITS  = 7;
    localparam int DEF_LOCK_COUNT = 3;

    typedef enum logic {
        FR_SEARCH = 1'b0,
        FR_TRACK  = 1'b1
    } fr_mode_e;

    // Forwarded clock pattern, first-sent bit at the MSB: two ones, zeros, two ones.
    function automatic logic [31:0] clk_pattern(input int bits);
        logic [31:0] p;
        p = '0;
        for (int i = 0; i < bits; i++) begin
            if (i < 2 || i >= bits - 2) begin
                p[bits - 1 - i] = 1'b1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sl7_tx_capture.sv
module sl7_tx_capture #(
    parameter int LANES     = sl7_pkg::DEF_LANES,
    parameter int LANE_BITS = sl7_pkg::DEF_LANE_BITS,
    localparam int WORD_W   = LANES * LANE_BITS
) (
    input  logic              clk_par,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_tog
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              tog;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.word = tx_word;
        cap_d.tog  = ~cap_q.tog;
    end

    always_ff @(posedge clk_par or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign hold_word = cap_q.word;
    assign hold_tog  = cap_q.tog;

    // R2: the held word only follows the input at a parallel edge
    a_r2_sample_edge: assert property (@(posedge clk_par) disable iff (!rst_n)
        1'b1 |=> (hold_word == $past(tx_word)));

endmodule

// File: rtl/sl7_tx_serializer.sv
module sl7_tx_serializer #(
    parameter int LANES     = sl7_pkg::DEF_LANES,
    parameter int LANE_BITS = sl7_pkg::DEF_LANE_BITS,
    localparam int WORD_W   = LANES * LANE_BITS
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              hold_tog,
    output logic [LANES-1:0]  ser_data_o,
    output logic              ser_clk_o
);

    localparam logic [LANE_BITS-1:0] PATTERN = LANE_BITS'(sl7_pkg::clk_pattern(LANE_BITS));

    typedef struct packed {
        logic                             seen;
        logic [LANES-1:0][LANE_BITS-1:0]  lane;
        logic [LANE_BITS-1:0]             clk;
    } tx_state_t;

    tx_state_t tx_d, tx_q;
    logic      load;

    assign load = (hold_tog != tx_q.seen);

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.seen = hold_tog;
            tx_d.clk  = PATTERN;
            for (int n = 0; n < LANES; n++) begin
                tx_d.lane[n] = hold_word[n*LANE_BITS +: LANE_BITS];
            end
        end else begin
            tx_d.clk = {tx_q.clk[LANE_BITS-2:0], 1'b0};
            for (int n = 0; n < LANES; n++) begin
                tx_d.lane[n] = {tx_q.lane[n][LANE_BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    for (genvar n = 0; n < LANES; n++) begin : g_lane_out
        assign ser_data_o[n] = tx_q.lane[n][LANE_BITS-1];
    end
    assign ser_clk_o = tx_q.clk[LANE_BITS-1];

    // R3: a fresh word puts its highest slice bit on each lane first
    a_r3_msb_first: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load |=> (ser_data_o[0] == $past(hold_word[LANE_BITS-1])
                  && ser_data_o[LANES-1] == $past(hold_word[WORD_W-1])));

    // R4: the clock lane opens every word with a one
    a_r4_clk_lane_start: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load |=> ser_clk_o);

endmodule

// File: rtl/sl7_rx_deser.sv
module sl7_rx_deser #(
    parameter int LANES     = sl7_pkg::DEF_LANES,
    parameter int LANE_BITS = sl7_pkg::DEF_LANE_BITS,
    localparam int WORD_W   = LANES * LANE_BITS
) (
    input  logic                 clk_fast,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     ser_data_i,
    input  logic                 ser_clk_i,
    output logic [WORD_W-1:0]    win_word,
    output logic [LANE_BITS-1:0] win_clk
);

    typedef struct packed {
        logic [LANES-1:0][LANE_BITS-1:0] lane;
        logic [LANE_BITS-1:0]            clk;
    } hist_state_t;

    hist_state_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.clk = {hist_q.clk[LANE_BITS-2:0], ser_clk_i};
        for (int n = 0; n < LANES; n++) begin
            hist_d.lane[n] = {hist_q.lane[n][LANE_BITS-2:0], ser_data_i[n]};
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // The oldest bit sits at the top of each window, which is the slice MSB.
    for (genvar n = 0; n < LANES; n++) begin : g_lane_word
        assign win_word[n*LANE_BITS +: LANE_BITS] = hist_q.lane[n];
    end
    assign win_clk = hist_q.clk;

    // R5: the newest window bit is the lane value from the previous edge
    a_r5_window_shift: assert property (@(posedge clk_fast) disable iff (!rst_n)
        1'b1 |=> (win_clk[0] == $past(ser_clk_i) && win_word[0] == $past(ser_data_i[0])));

endmodule

// File: rtl/sl7_rx_framer.sv
module sl7_rx_framer #(
    parameter int LANES      = sl7_pkg::DEF_LANES,
    parameter int LANE_BITS  = sl7_pkg::DEF_LANE_BITS,
    parameter int LOCK_COUNT = sl7_pkg::DEF_LOCK_COUNT,
    localparam int WORD_W    = LANES * LANE_BITS
) (
    input  logic                 clk_fast,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    win_word,
    input  logic [LANE_BITS-1:0] win_clk,
    output logic [WORD_W-1:0]    rx_word,
    output logic                 rx_par_clk,
    output logic                 rx_locked
);
    import sl7_pkg::*;

    localparam logic [LANE_BITS-1:0] PATTERN = LANE_BITS'(clk_pattern(LANE_BITS));
    localparam int PW        = $clog2(LANE_BITS);
    localparam int CW        = $clog2(LOCK_COUNT + 1);
    localparam int PCLK_RISE = LANE_BITS / 2;
    localparam logic [PW-1:0] LAST_PH = PW'(LANE_BITS - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_COUNT);

    typedef struct packed {
        fr_mode_e          mode;
        logic [PW-1:0]     phase;
        logic [CW-1:0]     good;
        logic              locked;
        logic [WORD_W-1:0] word;
        logic              pclk;
    } fr_state_t;

    fr_state_t fr_d, fr_q;
    logic      match;
    logic      at_edge;

    assign match   = (win_clk == PATTERN);
    assign at_edge = (fr_q.mode == FR_TRACK) && (fr_q.phase == LAST_PH);

    always_comb begin
        fr_d = fr_q;
        case (fr_q.mode)
            FR_SEARCH: begin
                if (match) begin
                    fr_d.mode   = FR_TRACK;
                    fr_d.phase  = '0;
                    fr_d.good   = CW'(1);
                    fr_d.word   = win_word;
                    fr_d.locked = (LOCK_COUNT <= 1);
                end
            end
            default: begin
                if (fr_q.phase == LAST_PH) begin
                    fr_d.phase = '0;
                    if (match) begin
                        fr_d.word   = win_word;
                        fr_d.good   = (fr_q.good == CNT_MAX) ? CNT_MAX : fr_q.good + CW'(1);
                        fr_d.locked = (fr_d.good >= CNT_MAX);
                    end else begin
                        fr_d.mode   = FR_SEARCH;
                        fr_d.good   = '0;
                        fr_d.locked = 1'b0;
                    end
                end else begin
                    fr_d.phase = fr_q.phase + PW'(1);
                end
            end
        endcase
        fr_d.pclk = (fr_d.mode == FR_TRACK) && (fr_d.phase >= PW'(PCLK_RISE));
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign rx_word    = fr_q.word;
    assign rx_par_clk = fr_q.pclk;
    assign rx_locked  = fr_q.locked;

    // R5: between boundaries the output word does not move
    a_r5_word_hold: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fr_q.mode == FR_TRACK && fr_q.phase != LAST_PH) |=> $stable(rx_word));

    // R6: a search without a matching window keeps the word
    a_r6_search_hold: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fr_q.mode == FR_SEARCH && !match) |=> ($stable(rx_word) && !rx_locked));

    // R7: the good pattern that completes the streak raises lock
    a_r7_lock_rise: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (at_edge && match && fr_q.good == CW'(LOCK_COUNT - 1)) |=> rx_locked);

    // R8: a bad boundary window drops lock and freezes the word
    a_r8_bad_drop: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (at_edge && !match) |=> (!rx_locked && $stable(rx_word)));

    // R9: the recovered clock is low right after every capture
    a_r9_pclk_low_on_capture: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (match && (fr_q.mode == FR_SEARCH || at_edge)) |=> !rx_par_clk);

endmodule

// File: rtl/sl7_link.sv
module sl7_link #(
    parameter int LANES      = sl7_pkg::DEF_LANES,
    parameter int LANE_BITS  = sl7_pkg::DEF_LANE_BITS,
    parameter int LOCK_COUNT = sl7_pkg::DEF_LOCK_COUNT,
    localparam int WORD_W    = LANES * LANE_BITS
) (
    input  logic              clk_fast,
    input  logic              clk_par,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic [LANES-1:0]  ser_data_o,
    output logic              ser_clk_o,
    input  logic [LANES-1:0]  ser_data_i,
    input  logic              ser_clk_i,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_par_clk,
    output logic              rx_locked
);

    logic [WORD_W-1:0]    hold_word;
    logic                 hold_tog;
    logic [WORD_W-1:0]    win_word;
    logic [LANE_BITS-1:0] win_clk;

    sl7_tx_capture #(.LANES(LANES), .LANE_BITS(LANE_BITS)) i_capture (
        .clk_par   (clk_par),
        .rst_n     (rst_n),
        .tx_word   (tx_word),
        .hold_word (hold_word),
        .hold_tog  (hold_tog)
    );

    sl7_tx_serializer #(.LANES(LANES), .LANE_BITS(LANE_BITS)) i_serializer (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .hold_word  (hold_word),
        .hold_tog   (hold_tog),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o)
    );

    sl7_rx_deser #(.LANES(LANES), .LANE_BITS(LANE_BITS)) i_deser (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .ser_data_i (ser_data_i),
        .ser_clk_i  (ser_clk_i),
        .win_word   (win_word),
        .win_clk    (win_clk)
    );

    sl7_rx_framer #(.LANES(LANES), .LANE_BITS(LANE_BITS), .LOCK_COUNT(LOCK_COUNT)) i_framer (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .win_word   (win_word),
        .win_clk    (win_clk),
        .rx_word    (rx_word),
        .rx_par_clk (rx_par_clk),
        .rx_locked  (rx_locked)
    );

endmodule

// File: tb/test_sl7_link.sv
module test_sl7_link;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 28;
    localparam int FIRST_S    = 14;   // fast edge of the first parallel sample
    localparam int BAD_K      = 8;    // word whose clock pattern is corrupted
    localparam int RUN_EDGES  = 200;

    logic              clk_fast = 1'b0;
    logic              clk_par  = 1'b0;
    logic              rst_n    = 1'b0;
    logic [WORD_W-1:0] tx_word  = '0;
    logic [3:0]        ser_data_o;
    logic              ser_clk_o;
    logic              ser_clk_i;
    logic [WORD_W-1:0] rx_word;
    logic              rx_par_clk;
    logic              rx_locked;
    logic              flip = 1'b0;

    int tests = 0;
    int fails = 0;
    int edges = 0;
    bit done  = 1'b0;
    logic [WORD_W-1:0] sent[$];

    assign ser_clk_i = ser_clk_o ^ flip;

    sl7_link i_sl7_link (
        .clk_fast   (clk_fast),
        .clk_par    (clk_par),
        .rst_n      (rst_n),
        .tx_word    (tx_word),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .ser_data_i (ser_data_o),
        .ser_clk_i  (ser_clk_i),
        .rx_word    (rx_word),
        .rx_par_clk (rx_par_clk),
        .rx_locked  (rx_locked)
    );

    initial forever #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    initial begin
        #(CLK_PERIOD/2);
        forever begin
            clk_par = 1'b1;
            #(4*CLK_PERIOD);
            clk_par = 1'b0;
            #(3*CLK_PERIOD);
        end
    end

    always @(posedge clk_fast) edges = edges + 1;

    function automatic logic [WORD_W-1:0] word_for(input int k);
        case (k)
            0: return 28'hFFFFFFF;
            1: return 28'h0000000;
            2: return 28'hAAAAAAA;
            3: return 28'h5555555;
            default: return WORD_W'((k * 32'h09E3779B) ^ 32'h01357BDF);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at time %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Reference model: state of the outputs after fast edge e.
    task automatic compare_all(input int e);
        logic [3:0]        exp_data;
        logic              exp_clk;
        logic [WORD_W-1:0] exp_word;
        logic              exp_lock;
        logic              exp_pclk;
        logic [6:0]        pat;
        int k, j, kk, lc, d;
        pat = 7'b1100011;
        exp_data = '0;
        exp_clk  = 1'b0;
        if (e >= FIRST_S + 1) begin
            k = (e - FIRST_S - 1) / 7;
            j = (e - FIRST_S - 1) % 7;
            for (int n = 0; n < 4; n++) begin
                exp_data[n] = sent[k][7*n + 6 - j];
            end
            exp_clk = pat[6 - j];
        end
        exp_word = '0;
        exp_lock = 1'b0;
        exp_pclk = 1'b0;
        if (e >= FIRST_S + 9) begin
            kk = (e - FIRST_S - 9) / 7;
            if (kk == BAD_K) begin
                exp_word = sent[BAD_K - 1];
                exp_lock = 1'b0;
                lc = FIRST_S + 9 + 7 * (BAD_K - 1);
            end else begin
                exp_word = sent[kk];
                exp_lock = (kk < BAD_K) ? (kk + 1 >= 3) : (kk - BAD_K >= 3);
                lc = FIRST_S + 9 + 7 * kk;
            end
            d = e - lc;
            exp_pclk = (d >= 3 && d <= 6);
        end
        if (e < FIRST_S) begin
            check("R1 reset data lanes", 32'(ser_data_o), 32'(exp_data));
            check("R1 reset clock lane", 32'(ser_clk_o), 32'(exp_clk));
            check("R1 reset rx_word", 32'(rx_word), 32'(exp_word));
            check("R1 reset rx_locked", 32'(rx_locked), 32'(exp_lock));
            check("R1 reset rx_par_clk", 32'(rx_par_clk), 32'(exp_pclk));
        end else begin
            check("R2/R3 data lanes", 32'(ser_data_o), 32'(exp_data));
            check("R4 clock lane", 32'(ser_clk_o), 32'(exp_clk));
            check("R5/R6/R8 rx_word", 32'(rx_word), 32'(exp_word));
            check("R7/R8 rx_locked", 32'(rx_locked), 32'(exp_lock));
            check("R9 rx_par_clk", 32'(rx_par_clk), 32'(exp_pclk));
        end
    endtask

    initial begin
        int e;
        for (int step = 0; step < RUN_EDGES; step++) begin
            @(negedge clk_fast);
            e = edges - 1;
            compare_all(e);
            if (e == FIRST_S - 1) rst_n = 1'b1;
            // R2: disturb the input in the middle of every parallel period
            if (e >= FIRST_S && (e % 7) == 3) tx_word = ~sent[sent.size() - 1];
            if (e >= FIRST_S - 1 && (e % 7) == 6) begin
                tx_word = word_for(sent.size());
                sent.push_back(tx_word);
            end
            // R8: invert the last clock-lane bit of word BAD_K on the loopback
            if (e == FIRST_S + 7 * BAD_K + 7) flip = 1'b1;
            if (e == FIRST_S + 7 * BAD_K + 8) flip = 1'b0;
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule